// File: doc/BRIEF.md
# Byte-Wide Host Result Port

This block connects a result buffer to an external host over an 8-bit parallel bus. When the decoder hands over a new 36-byte result record, the block stores it and pulls an active-low interrupt line low. The host then reads the record one byte at a time. It lowers read-enable, and the block fetches the next byte onto the data pins. A pacing line dips low for a fixed number of clocks and rises when the byte is valid. A second line, hold, falls at that moment and rises again once the host releases read-enable. Byte 0 and byte 1 carry status: the block number, the correction kind, the correction result and the two lock flags. Bytes 2 to 35 carry corrected block data. The block does not interpret any of these bytes.

The same pins also carry register writes from the host. While the store strobe is low, the pins turn around to inputs. The 3-bit port address and the data byte are handed on as a single-cycle write when the strobe rises. A mode input selects serial operation. In serial mode the pins are parked low, both ready lines stay high, and the block ignores host reads and strobes.

The record input is a plain valid strobe with no back-pressure. A new record replaces the stored one at once, even if the host is still reading. The host must finish reading before the next record arrives, which is roughly 9 ms after the interrupt. The write output is a valid pulse with no ready. The consumer must take it in the cycle it appears.

Top module: `hostport_par`

## Requirements
- R1: During and after reset, irq_n, pace_n and hold_n are 1, wr_valid is 0, dat_o is 0x00, and dat_oe is 1 while st_n is high.
- R2: A rec_valid pulse drives irq_n low on the next clock. irq_n returns to 1 when the first read-enable falling edge of that record is detected.
- R3: After a detected read-enable fall (in parallel mode), pace_n is low for exactly PACE_CYCLES clocks. At the clock where pace_n rises, hold_n falls and dat_o holds the fetched byte.
- R4: When the synchronized read-enable returns high, hold_n and pace_n are 1 by the next clock, and the read pointer advances by one.
- R5: Bytes are delivered in order 0,1,2,… where byte k is rec_data[8k+7:8k]. Bytes 0 and 1 are the status bytes.
- R6: Reads beyond byte REC_BYTES-1 return 0x00, and the pointer stays saturated there.
- R7: A rec_valid pulse restarts the read at byte 0, even when the previous record was only partly read or a read is in progress.
- R8: In parallel mode, dat_oe is 0 whenever st_n is low.
- R9: When the synchronized store strobe rises, wr_valid is 1 for exactly one clock. wr_addr and wr_data carry port_addr and dat_i as sampled while the strobe was low.
- R10: With ser_mode=1, dat_o is 0x00, dat_oe is 1, and pace_n and hold_n are 1. rd_n and st_n are ignored, so the pointer does not move and no write is issued. irq_n still follows R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_mode | input | 1 | 1 = serial mode (pins parked), 0 = parallel |
| rec_valid | input | 1 | One-cycle strobe: new record on rec_data |
| rec_data | input | REC_BYTES*8 | Record, byte k in bits 8k+7:8k |
| rd_n | input | 1 | Host read-enable, active low, asynchronous |
| st_n | input | 1 | Host store strobe, active low, asynchronous |
| port_addr | input | ADDR_W | Host register address |
| dat_i | input | 8 | Data pins, input side |
| dat_o | output | 8 | Data pins, output side |
| dat_oe | output | 1 | Data pin output enable |
| pace_n | output | 1 | Pacing ready: dips low, rises when byte valid |
| hold_n | output | 1 | Hold ready: low from byte valid until read-enable high |
| irq_n | output | 1 | Active-low record interrupt |
| wr_valid | output | 1 | One-cycle register write strobe |
| wr_addr | output | ADDR_W | Register write address |
| wr_data | output | 8 | Register write data |

## Verification
The bench uses the default parameters: 36-byte records, an 8-clock pace window and two synchronizer stages. These defaults let it read a whole record and two bytes past its end within a short run. They also make the pace window long enough to count exactly at the ports. Directed scenarios cover a record abandoned partway, a store strobe interleaved with reads, and a serial-mode phase in which reads must leave the pointer untouched.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hp_reader.sv
module hp_reader
  import hp_pkg::*;
#(
  parameter int REC_BYTES   = 36,
  parameter int PACE_CYCLES = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic                      rec_valid,
  input  logic [REC_BYTES*BYTE_W-1:0] rec_data,
  input  logic                      rd_s,
  output byte_t                     byte_q,
  output logic                      pace_n,
  output logic                      hold_n,
  output logic                      irq_n
);
  localparam int PTR_W = $clog2(REC_BYTES + 1);
  localparam int CNT_W = $clog2(PACE_CYCLES + 1);
  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(REC_BYTES);

  byte_t            mem [REC_BYTES];
  logic [PTR_W-1:0] ptr;
  logic [CNT_W-1:0] cnt;
  logic             rd_prev, pend, active;
  byte_t            sel;

  // stored copy of the record; data only, no reset needed
  always_ff @(posedge clk) begin
    if (rec_valid)
      for (int k = 0; k < REC_BYTES; k++) mem[k] <= rec_data[k*BYTE_W +: BYTE_W];
  end

  // byte select; a saturated pointer selects 0x00
  always_comb begin
    sel = '0;
    for (int k = 0; k < REC_BYTES; k++)
      if (ptr == PTR_W'(k)) sel = mem[k];
  end

  wire rd_fall = en && rd_prev && !rd_s;
  wire rd_rise = en && !rd_prev && rd_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_prev <= 1'b1;
      ptr     <= '0;
      cnt     <= '0;
      pend    <= 1'b0;
      active  <= 1'b0;
      byte_q  <= '0;
      pace_n  <= 1'b1;
      hold_n  <= 1'b1;
      irq_n   <= 1'b1;
    end else begin
      rd_prev <= rd_s;
      if (rec_valid) begin
        ptr    <= '0;
        irq_n  <= 1'b0;
        pace_n <= 1'b1;
        hold_n <= 1'b1;
        pend   <= 1'b0;
        active <= 1'b0;
      end else if (rd_fall) begin
        irq_n  <= 1'b1;
        byte_q <= sel;
        pace_n <= 1'b0;
        hold_n <= 1'b1;
        cnt    <= CNT_W'(PACE_CYCLES - 1);
        pend   <= 1'b1;
        active <= 1'b1;
      end else if (rd_rise) begin
        pace_n <= 1'b1;
        hold_n <= 1'b1;
        pend   <= 1'b0;
        active <= 1'b0;
        if (active && ptr != PTR_END) ptr <= ptr + 1'b1;
      end else if (pend) begin
        if (cnt == '0) begin
          pace_n <= 1'b1;
          hold_n <= 1'b0;
          pend   <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hp_store.sv
module hp_store
  import hp_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              st_s,
  input  logic [ADDR_W-1:0] port_addr,
  input  byte_t             dat_i,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output byte_t             wr_data
);
  logic              st_prev;
  logic [ADDR_W-1:0] a_cap;
  byte_t             d_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_prev  <= 1'b1;
      a_cap    <= '0;
      d_cap    <= '0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      st_prev  <= st_s;
      wr_valid <= 1'b0;
      if (!st_s) begin
        a_cap <= port_addr;
        d_cap <= dat_i;
      end
      if (en && st_s && !st_prev) begin
        wr_valid <= 1'b1;
        wr_addr  <= a_cap;
        wr_data  <= d_cap;
      end
    end
  end
endmodule

// File: rtl/hostport_par.sv
module hostport_par
  import hp_pkg::*;
#(
  parameter int REC_BYTES   = 36,
  parameter int PACE_CYCLES = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ser_mode,
  input  logic                        rec_valid,
  input  logic [REC_BYTES*BYTE_W-1:0] rec_data,
  input  logic                        rd_n,
  input  logic                        st_n,
  input  logic [ADDR_W-1:0]           port_addr,
  input  logic [BYTE_W-1:0]           dat_i,
  output logic [BYTE_W-1:0]           dat_o,
  output logic                        dat_oe,
  output logic                        pace_n,
  output logic                        hold_n,
  output logic                        irq_n,
  output logic                        wr_valid,
  output logic [ADDR_W-1:0]           wr_addr,
  output logic [BYTE_W-1:0]           wr_data
);
  logic  rd_s, st_s, pace_int, hold_int;
  byte_t byte_q;
  wire   par = !ser_mode;

  hp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_rd_sync (
    .clk(clk), .rst_n(rst_n), .d(rd_n), .q(rd_s));
  hp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_st_sync (
    .clk(clk), .rst_n(rst_n), .d(st_n), .q(st_s));

  hp_reader #(.REC_BYTES(REC_BYTES), .PACE_CYCLES(PACE_CYCLES)) i_reader (
    .clk(clk), .rst_n(rst_n), .en(par), .rec_valid(rec_valid),
    .rec_data(rec_data), .rd_s(rd_s), .byte_q(byte_q),
    .pace_n(pace_int), .hold_n(hold_int), .irq_n(irq_n));

  hp_store #(.ADDR_W(ADDR_W)) i_store (
    .clk(clk), .rst_n(rst_n), .en(par), .st_s(st_s),
    .port_addr(port_addr), .dat_i(dat_i),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data));

  // pin turnaround follows the raw strobe so the host never fights the port
  assign dat_oe = ser_mode || st_n;
  assign dat_o  = ser_mode ? '0 : byte_q;
  assign pace_n = ser_mode || pace_int;
  assign hold_n = ser_mode || hold_int;
endmodule

// File: rtl/hostport_par_chk.sv
module hostport_par_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ser_mode,
  input logic              rec_valid,
  input logic              st_n,
  input logic [7:0]        dat_o,
  input logic              dat_oe,
  input logic              pace_n,
  input logic              hold_n,
  input logic              irq_n,
  input logic              wr_valid
);
  AST_IRQ_ON_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |=> !irq_n); // R2

  AST_HOLD_AFTER_PACE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_mode && $fell(hold_n)) |-> $rose(pace_n)); // R3

  AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(pace_n == 1'b0 && hold_n == 1'b0)); // R3

  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_mode && !st_n) |-> !dat_oe); // R8

  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid); // R9

  AST_SERIAL_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    ser_mode |-> (dat_o == 8'h00 && dat_oe && pace_n && hold_n)); // R10

  AST_SERIAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ser_mode) && ser_mode) |-> !wr_valid); // R10
endmodule

bind hostport_par hostport_par_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .ser_mode(ser_mode), .rec_valid(rec_valid),
  .st_n(st_n), .dat_o(dat_o), .dat_oe(dat_oe), .pace_n(pace_n),
  .hold_n(hold_n), .irq_n(irq_n), .wr_valid(wr_valid));

// File: tb/test_hostport_par.sv
module test_hostport_par;
  localparam int CLK_PERIOD = 10;
  localparam int REC_BYTES  = 36;
  localparam int PACE       = 8;
  localparam int ADDR_W     = 3;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0, rst_n = 1'b0, ser_mode = 1'b0, rec_valid = 1'b0;
  logic [REC_BYTES*8-1:0] rec_data = '0;
  logic rd_n = 1'b1, st_n = 1'b1;
  logic [ADDR_W-1:0] port_addr = '0;
  logic [7:0] dat_i = '0, dat_o;
  logic dat_oe, pace_n, hold_n, irq_n, wr_valid;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0] wr_data;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hostport_par #(.REC_BYTES(REC_BYTES), .PACE_CYCLES(PACE), .SYNC_STAGES(2),
                 .ADDR_W(ADDR_W)) i_hostport_par (
    .clk(clk), .rst_n(rst_n), .ser_mode(ser_mode), .rec_valid(rec_valid),
    .rec_data(rec_data), .rd_n(rd_n), .st_n(st_n), .port_addr(port_addr),
    .dat_i(dat_i), .dat_o(dat_o), .dat_oe(dat_oe), .pace_n(pace_n),
    .hold_n(hold_n), .irq_n(irq_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rbyte(input int seed, input int k);
    return 8'((seed * 31 + k * 13 + 5) & 255);
  endfunction

  // load a record; checks R2 (interrupt falls one clock later)
  task automatic load_rec(input int seed);
    @(negedge clk);
    for (int k = 0; k < REC_BYTES; k++) rec_data[k*8 +: 8] = rbyte(seed, k);
    rec_valid = 1'b1;
    @(negedge clk);
    rec_valid = 1'b0;
    chk(irq_n == 1'b0, "R2 irq low after record", int'(irq_n), 0);
  endtask

  // one byte read; R3 pace window and byte, R4 release
  task automatic read_byte(input logic [7:0] exp, input string req);
    int low = 0;
    bit seen = 1'b0;
    @(negedge clk);
    rd_n = 1'b0;
    for (int i = 0; i < 40 && !seen; i++) begin
      @(negedge clk);
      if (hold_n == 1'b0) seen = 1'b1;
      else if (pace_n == 1'b0) low++;
    end
    chk(seen, "R3 hold fell", int'(seen), 1);
    chk(low == PACE, "R3 pace low width", low, PACE);
    chk(dat_o == exp, req, int'(dat_o), int'(exp));
    rd_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(hold_n && pace_n, "R4 ready lines released", int'({hold_n, pace_n}), 3);
  endtask

  task automatic t_reset;
    repeat (2) @(negedge clk);
    chk(irq_n && pace_n && hold_n, "R1 ready/irq in reset", int'({irq_n, pace_n, hold_n}), 7);
    chk(dat_o == 8'h00 && dat_oe, "R1 pins in reset", int'({dat_oe, dat_o}), 'h100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!wr_valid && irq_n, "R1 after reset", int'({wr_valid, irq_n}), 1);
  endtask

  task automatic t_full_record;
    load_rec(3);
    read_byte(rbyte(3, 0), "R5 status byte 0");
    chk(irq_n == 1'b1, "R2 irq released on first read", int'(irq_n), 1);
    for (int k = 1; k < REC_BYTES; k++) read_byte(rbyte(3, k), "R5 byte order");
    read_byte(8'h00, "R6 past end byte 36");
    read_byte(8'h00, "R6 past end byte 37");
  endtask

  task automatic t_abandon;
    load_rec(9);
    read_byte(rbyte(9, 0), "R5 byte 0");
    read_byte(rbyte(9, 1), "R5 byte 1");
    // new record arrives while read-enable is low
    @(negedge clk);
    rd_n = 1'b0;
    repeat (5) @(negedge clk);
    load_rec(17);
    rd_n = 1'b1;
    repeat (4) @(negedge clk);
    read_byte(rbyte(17, 0), "R7 restart at byte 0");
    read_byte(rbyte(17, 1), "R7 then byte 1");
  endtask

  task automatic t_store(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    int pulses = 0;
    @(negedge clk);
    port_addr = a;
    dat_i = d;
    st_n = 1'b0;
    @(negedge clk);
    chk(dat_oe == 1'b0, "R8 pins are inputs while strobe low", int'(dat_oe), 0);
    repeat (3) @(negedge clk);
    st_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (wr_valid) begin
        pulses++;
        chk(wr_addr == a && wr_data == d, "R9 write fields",
            int'({wr_addr, wr_data}), int'({a, d}));
      end
    end
    chk(pulses == 1, "R9 single write pulse", pulses, 1);
    chk(dat_oe == 1'b1, "R8 pins drive after strobe", int'(dat_oe), 1);
    port_addr = '0;
    dat_i = '0;
  endtask

  task automatic t_serial;
    int bad = 0, wr = 0;
    load_rec(23);
    @(negedge clk);
    ser_mode = 1'b1;
    @(negedge clk);
    chk(dat_o == 8'h00 && dat_oe, "R10 pins parked low", int'({dat_oe, dat_o}), 'h100);
    for (int r = 0; r < 3; r++) begin
      rd_n = 1'b0;
      st_n = 1'b0;
      for (int i = 0; i < 14; i++) begin
        @(negedge clk);
        if (!pace_n || !hold_n || dat_o != 8'h00 || !dat_oe) bad++;
        if (wr_valid) wr++;
      end
      rd_n = 1'b1;
      st_n = 1'b1;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (wr_valid) wr++;
      end
    end
    chk(bad == 0, "R10 outputs parked during host activity", bad, 0);
    chk(wr == 0, "R10 no write in serial mode", wr, 0);
    ser_mode = 1'b0;
    repeat (2) @(negedge clk);
    read_byte(rbyte(23, 0), "R10 pointer unmoved by serial reads");
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_full_record();
    t_abandon();
    t_store(3'd5, 8'hA7);
    t_store(3'd0, 8'h3C);
    t_serial();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule